// File: doc/BRIEF.md
# Floating-Point Issue Timing Controller

This block sits in front of a set of partly pipelined floating-point functional units and decides, cycle by cycle, whether the operation being requested may enter its unit. It performs no arithmetic. It models only timing and hazards. Each operation class has its own result latency and its own minimum spacing between issues into the same unit, called the initiation interval. The controller keeps a separate busy window for every unit instead of assuming one pipeline depth.

A requester presents an operation code, a destination tag and a valid bit. The controller answers with a grant in the same cycle. A refused request stays on the inputs until it is granted. For every granted operation, the controller returns the tag with a one-cycle result pulse exactly the operation's latency later. Two further resources are protected. The first is the single result slot per cycle. The second is the adder, whose hardware also performs the final step of multiply and divide.

Top module: `fpi_issue_ctrl`

## Requirements
- R1: While `rst_n` is low, `grant` and `res_valid` are both low. After reset, no result is pending and every unit is free.
- R2: `grant` is a combinational answer in the cycle of the request. It is never high without `req_valid`.
- R3: Operation codes and default latencies are: 0 add/subtract, 4 cycles; 1 multiply, 8; 2 divide, 36; 3 square root, 112; 4 negate, 2; 5 absolute value, 2; 6 compare, 3. An operation granted in cycle c produces `res_valid` high in cycle c+latency.
- R4: `res_tag` in the result cycle equals the `req_tag` presented with the grant.
- R5: Default initiation intervals are: add 3, multiply 4, divide 35, square root 111, compare 2. After a grant in cycle c, a request for the same unit is refused until cycle c+interval.
- R6: Negate and absolute value share one unit whose interval is 1. They can be granted in consecutive cycles in any mix.
- R7: Units are independent. A busy unit does not by itself block a request for a different unit.
- R8: A request is refused if its result cycle already holds a pending result. Result pulses never collide.
- R9: An add occupies the adder in its grant cycle and the next interval−1 cycles. A multiply uses the adder in cycle grant+latency−1, and so does a divide. A request whose adder cycle or cycles overlap an existing use is refused.
- R10: Operation code 7 is reserved and is never granted.
- R11: Each grant produces exactly one result pulse, lasting one cycle. A cycle with no scheduled completion shows `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Issue request present |
| req_op | input | 3 | Operation code (R3 encoding) |
| req_tag | input | TAG_W | Destination tag of the request |
| grant | output | 1 | Request accepted this cycle |
| res_valid | output | 1 | One-cycle result-available pulse |
| res_tag | output | TAG_W | Tag of the completing operation |

## Verification
The bench builds the controller with its default timing parameters and a 4-bit tag, so the full 112-cycle square-root window and the 35-cycle divide window are covered. Every ordered pair of legal operation codes is issued at six different spacings. The second request is held until granted, which exercises interval refusals, result-slot collisions between short and long operations, and adder contention between add and the final step of multiply or divide. An arithmetic model of the stated latencies and intervals predicts every grant and every result cycle.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

   typedef enum logic [2:0] {
      OP_ADDSUB = 3'd0,
      OP_MUL    = 3'd1,
      OP_DIV    = 3'd2,
      OP_SQRT   = 3'd3,
      OP_NEG    = 3'd4,
      OP_ABS    = 3'd5,
      OP_CMP    = 3'd6,
      OP_RSVD   = 3'd7
   } fp_op_e;

   localparam int N_UNITS = 6;
   localparam logic [2:0] U_ADD  = 3'd0;
   localparam logic [2:0] U_MUL  = 3'd1;
   localparam logic [2:0] U_DIV  = 3'd2;
   localparam logic [2:0] U_SQRT = 3'd3;
   localparam logic [2:0] U_SIGN = 3'd4;
   localparam logic [2:0] U_CMP  = 3'd5;

   function automatic logic [2:0] op_unit(fp_op_e op);
      case (op)
         OP_ADDSUB: return U_ADD;
         OP_MUL:    return U_MUL;
         OP_DIV:    return U_DIV;
         OP_SQRT:   return U_SQRT;
         OP_NEG,
         OP_ABS:    return U_SIGN;
         OP_CMP:    return U_CMP;
         default:   return U_ADD;
      endcase
   endfunction

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpi_ii_timer.sv
module fpi_ii_timer #(
   parameter int unsigned II = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic free
);
   localparam int unsigned CW = (II > 2) ? $clog2(II) : 1;

   logic [CW-1:0] cnt;

   initial begin : p_param_chk
      a_r5_interval_positive: assert (II >= 1)
         else $error("initiation interval must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (issue)       cnt <= CW'(II - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign free = (cnt == '0);

   // R5: the unit never accepts an issue inside its interval window
   a_r5_no_issue_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !issue);

endmodule

// File: rtl/fpi_result_sched.sv
module fpi_result_sched #(
   parameter int unsigned TAG_W = 4,
   parameter int unsigned MAXL  = 112,
   parameter int unsigned LW    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    q_lat,
   output logic             q_busy,
   input  logic             load,
   input  logic [TAG_W-1:0] load_tag,
   output logic             res_valid,
   output logic [TAG_W-1:0] res_tag
);
   // pend_v[k] set: a result leaves k cycles from now; top entry stays empty
   logic [MAXL:0]    pend_v;
   logic [TAG_W-1:0] pend_tag [MAXL+1];
   logic [LW-1:0]    ld_idx;

   assign ld_idx = q_lat - LW'(1);
   assign q_busy = pend_v[q_lat];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v <= '0;
      end else begin
         for (int k = 0; k < int'(MAXL); k++)
            pend_v[k] <= (load && ld_idx == LW'(k)) ? 1'b1 : pend_v[k+1];
         pend_v[MAXL] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < int'(MAXL); k++)
         pend_tag[k] <= (load && ld_idx == LW'(k)) ? load_tag : pend_tag[k+1];
      pend_tag[MAXL] <= '0;
   end

   assign res_valid = pend_v[0];
   assign res_tag   = pend_tag[0];

   // R8: a newly loaded result never lands on an occupied slot
   a_r8_no_double_book: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !pend_v[q_lat]);

endmodule

// File: rtl/fpi_adder_rsv.sv
module fpi_adder_rsv #(
   parameter int unsigned RD     = 36,
   parameter int unsigned HOLD   = 3,
   parameter int unsigned MUL_AT = 7,
   parameter int unsigned DIV_AT = 35
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take_add,
   input  logic take_mul,
   input  logic take_div,
   output logic ok_add,
   output logic ok_mul,
   output logic ok_div
);
   // rsv[k] set: adder is in use k cycles from now
   logic [RD-1:0] rsv;
   logic [RD-1:0] set_v;

   initial begin : p_param_chk
      a_r9_slots_in_range: assert (MUL_AT < RD && DIV_AT < RD && HOLD <= RD && HOLD >= 1)
         else $error("adder reservation window too short");
   end

   always_comb begin
      ok_add = 1'b1;
      for (int k = 0; k < int'(HOLD); k++)
         if (rsv[k]) ok_add = 1'b0;
      ok_mul = !rsv[MUL_AT];
      ok_div = !rsv[DIV_AT];
   end

   genvar g;
   generate
      for (g = 0; g < int'(RD); g++) begin : g_set
         if (g + 1 < int'(HOLD)) begin : g_hold
            assign set_v[g] = take_add
                              | (take_mul && (g + 1 == int'(MUL_AT)))
                              | (take_div && (g + 1 == int'(DIV_AT)));
         end else begin : g_tail
            assign set_v[g] = (take_mul && (g + 1 == int'(MUL_AT)))
                              | (take_div && (g + 1 == int'(DIV_AT)));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) rsv <= '0;
      else        rsv <= {1'b0, rsv[RD-1:1]} | set_v;
   end

   // R9: multiply and divide claim their final adder cycle only when it is free
   a_r9_mul_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
      take_mul |-> !rsv[MUL_AT]);
   a_r9_div_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
      take_div |-> !rsv[DIV_AT]);

endmodule

// File: rtl/fpi_issue_ctrl.sv
module fpi_issue_ctrl
   import fpi_pkg::*;
#(
   parameter int unsigned TAG_W    = 4,
   parameter int unsigned LAT_ADD  = 4,
   parameter int unsigned II_ADD   = 3,
   parameter int unsigned LAT_MUL  = 8,
   parameter int unsigned II_MUL   = 4,
   parameter int unsigned LAT_DIV  = 36,
   parameter int unsigned II_DIV   = 35,
   parameter int unsigned LAT_SQRT = 112,
   parameter int unsigned II_SQRT  = 111,
   parameter int unsigned LAT_SIGN = 2,
   parameter int unsigned II_SIGN  = 1,
   parameter int unsigned LAT_CMP  = 3,
   parameter int unsigned II_CMP   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [TAG_W-1:0] req_tag,
   output logic             grant,
   output logic             res_valid,
   output logic [TAG_W-1:0] res_tag
);
   localparam int unsigned MAXL = max2(max2(max2(LAT_ADD, LAT_MUL), max2(LAT_DIV, LAT_SQRT)),
                                       max2(LAT_SIGN, LAT_CMP));
   localparam int unsigned LW   = $clog2(MAXL + 1);
   localparam int unsigned RD   = max2(LAT_MUL, LAT_DIV);
   localparam int unsigned II_TBL [N_UNITS] = '{II_ADD, II_MUL, II_DIV, II_SQRT, II_SIGN, II_CMP};

   initial begin : p_param_chk
      a_r3_latency_floor: assert (LAT_ADD >= 1 && LAT_MUL >= 2 && LAT_DIV >= 2 &&
                                  LAT_SQRT >= 1 && LAT_SIGN >= 1 && LAT_CMP >= 1)
         else $error("latency parameters out of range");
   end

   fp_op_e               op;
   logic                 legal;
   logic [2:0]           unit_sel;
   logic [N_UNITS-1:0]   unit_free;
   logic [N_UNITS-1:0]   unit_issue;
   logic [LW-1:0]        sel_lat;
   logic                 slot_busy;
   logic                 ok_add, ok_mul, ok_div, adder_ok;

   assign op       = fp_op_e'(req_op);
   assign legal    = (op != OP_RSVD);
   assign unit_sel = op_unit(op);

   always_comb begin
      case (op)
         OP_ADDSUB:      begin sel_lat = LW'(LAT_ADD);  adder_ok = ok_add; end
         OP_MUL:         begin sel_lat = LW'(LAT_MUL);  adder_ok = ok_mul; end
         OP_DIV:         begin sel_lat = LW'(LAT_DIV);  adder_ok = ok_div; end
         OP_SQRT:        begin sel_lat = LW'(LAT_SQRT); adder_ok = 1'b1;   end
         OP_NEG, OP_ABS: begin sel_lat = LW'(LAT_SIGN); adder_ok = 1'b1;   end
         OP_CMP:         begin sel_lat = LW'(LAT_CMP);  adder_ok = 1'b1;   end
         default:        begin sel_lat = LW'(1);        adder_ok = 1'b0;   end
      endcase
   end

   logic sel_unit_free;
   always_comb begin
      sel_unit_free = 1'b0;
      for (int u = 0; u < N_UNITS; u++)
         if (unit_sel == 3'(u)) sel_unit_free = unit_free[u];
   end

   assign grant = rst_n && req_valid && legal && sel_unit_free && !slot_busy && adder_ok;

   genvar g;
   generate
      for (g = 0; g < N_UNITS; g++) begin : g_unit
         assign unit_issue[g] = grant && (unit_sel == 3'(g));
         fpi_ii_timer #(.II(II_TBL[g])) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .issue (unit_issue[g]),
            .free  (unit_free[g])
         );
      end
   endgenerate

   fpi_adder_rsv #(
      .RD     (RD),
      .HOLD   (II_ADD),
      .MUL_AT (LAT_MUL - 1),
      .DIV_AT (LAT_DIV - 1)
   ) u_adder (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_add (unit_issue[U_ADD]),
      .take_mul (unit_issue[U_MUL]),
      .take_div (unit_issue[U_DIV]),
      .ok_add   (ok_add),
      .ok_mul   (ok_mul),
      .ok_div   (ok_div)
   );

   fpi_result_sched #(
      .TAG_W (TAG_W),
      .MAXL  (MAXL),
      .LW    (LW)
   ) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_lat     (sel_lat),
      .q_busy    (slot_busy),
      .load      (grant),
      .load_tag  (req_tag),
      .res_valid (res_valid),
      .res_tag   (res_tag)
   );

   // R2: no grant without a request
   a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req_valid);
   // R10: reserved code is never accepted
   a_r10_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (req_op != 3'd7));

endmodule

// File: tb/fpi_issue_ctrl_bench.sv
`timescale 1ns/1ps
module fpi_issue_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_op = 3'd0;
   logic [3:0] req_tag = 4'd0;
   logic       grant, res_valid;
   logic [3:0] res_tag;

   always #4 clk = ~clk;

   fpi_issue_ctrl #(.TAG_W(4)) u_fpi_issue_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_tag(req_tag), .grant(grant), .res_valid(res_valid), .res_tag(res_tag)
   );

   // model constants taken from R3, R5, R6 (index = op code)
   int LAT [7] = '{4, 8, 36, 112, 2, 2, 3};
   int UNT [7] = '{0, 1, 2, 3, 4, 4, 5};
   int IIU [6] = '{3, 4, 35, 111, 1, 2};

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 0;
   int ufree [6];
   bit exp_v [256];
   logic [3:0] exp_tag [256];
   bit abusy [256];
   logic [3:0] tag_ctr = 4'd1;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic step(input bit v, input logic [2:0] op, output bit got);
      int s, u, l;
      bit eg;
      string why;
      @(negedge clk);
      req_valid = v; req_op = op; req_tag = tag_ctr;
      #1;
      s = cyc % 256;
      chk("R3/R11 result pulse timing", int'(res_valid), int'(exp_v[s]));
      if (exp_v[s]) chk("R4 result tag", int'(res_tag), int'(exp_tag[s]));
      exp_v[s] = 0;
      eg = 0; why = "R2 idle no grant";
      if (v) begin
         if (op == 3'd7) why = "R10 reserved code";
         else begin
            u = UNT[op]; l = LAT[op];
            if (cyc < ufree[u]) why = (u == 4) ? "R6 sign unit interval" : "R5 initiation interval";
            else if (exp_v[(cyc + l) % 256]) why = "R8 result collision";
            else if (op == 3'd0 && (abusy[s] || abusy[(cyc+1)%256] || abusy[(cyc+2)%256]))
               why = "R9 adder busy for add";
            else if (op == 3'd1 && abusy[(cyc+7)%256]) why = "R9 adder busy for mul";
            else if (op == 3'd2 && abusy[(cyc+35)%256]) why = "R9 adder busy for div";
            else begin eg = 1; why = "R2/R7 grant"; end
         end
      end
      chk(why, int'(grant), int'(eg));
      if (eg) begin
         ufree[u] = cyc + IIU[u];
         exp_v[(cyc + l) % 256] = 1;
         exp_tag[(cyc + l) % 256] = tag_ctr;
         if (op == 3'd0) begin
            abusy[s] = 1; abusy[(cyc+1)%256] = 1; abusy[(cyc+2)%256] = 1;
         end
         if (op == 3'd1) abusy[(cyc+7)%256] = 1;
         if (op == 3'd2) abusy[(cyc+35)%256] = 1;
      end
      abusy[s] = 0;
      got = grant;
      if (grant) tag_ctr = tag_ctr + 4'd1;
      cyc++;
   endtask

   task automatic hold(input logic [2:0] op);
      bit got;
      for (int t = 0; t < 300; t++) begin
         step(1'b1, op, got);
         if (got) break;
      end
   endtask

   task automatic idle(input int n);
      bit got;
      for (int t = 0; t < n; t++) step(1'b0, 3'd0, got);
   endtask

   initial begin
      int gaps [6] = '{0, 1, 2, 3, 5, 7};
      bit got;
      for (int k = 0; k < 6; k++) ufree[k] = 0;
      // R1: in reset nothing is granted and no result appears
      req_valid = 1'b1;
      for (int t = 0; t < 4; t++) begin
         @(negedge clk); #1;
         chk("R1 grant in reset", int'(grant), 0);
         chk("R1 result in reset", int'(res_valid), 0);
      end
      @(negedge clk); rst_n = 1'b1; req_valid = 1'b0;
      // R10: reserved code held for several cycles
      for (int t = 0; t < 5; t++) step(1'b1, 3'd7, got);
      // R6: negate/absolute value back to back
      step(1'b1, 3'd4, got); step(1'b1, 3'd5, got); step(1'b1, 3'd4, got);
      idle(10);
      // R5 R7 R8 R9: every ordered pair at several spacings
      for (int a = 0; a < 7; a++)
         for (int b = 0; b < 7; b++)
            for (int gi = 0; gi < 6; gi++) begin
               hold(3'(a));
               idle(gaps[gi]);
               hold(3'(b));
               idle(120);
            end
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(190000 * 8);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule